// File: doc/BRIEF.md
# Selectable-Concurrency Ready/Valid Elastic Stage

This block is one pipeline stage of a ready/valid stream. It carries a word of parameterised width from an upstream producer to a downstream consumer, and it holds words whenever the consumer stalls. A transfer on either side happens only in a cycle where that side's valid and ready are both 1. When the stage offers a word downstream and ready_in is 0, the word and valid_out stay unchanged until a transfer takes place. The producer has to obey the same rule toward the stage: a word it offers must not change until ready_out accepts it.

The parameter `MODE` selects one of four organisations, and each one trades throughput against timing isolation. MODE 0 is the half-rate cell. It has one slot, and in any cycle it either accepts or releases a word, never both. MODE 1 is the overlap cell. It has one slot and accepts a new word while full if the stored word leaves in the same cycle, so ready_in reaches ready_out through logic. MODE 2 is the pass-through cell. It has one slot, and while empty it passes valid_in and data_in straight to the outputs. MODE 3 is the twin cell. Two half-rate slots are used in alternation under 1-bit write and read pointers, and all of its handshake outputs come from registers.

Top module: `rv_elastic_stage`

## Requirements
- R1: After a synchronous reset, valid_out is 0 and ready_out is 1 in every mode. All slot flags and both twin pointers are cleared.
- R2: In every mode, each accepted word leaves exactly once and in order. Nothing is lost or duplicated under arbitrary valid and ready stalls. A slot marked full offers valid_out.
- R3: While valid_out is 1 and ready_in is 0, valid_out stays 1 and data_out stays unchanged in the next cycle.
- R4: MODE 0 never accepts and releases in the same cycle. Under continuous flow it moves one word every two cycles. ready_out is 0 while the slot is full, whatever the value of ready_in.
- R5: MODE 1 raises ready_out in the same cycle when it is full and ready_in is 1, and lowers it when ready_in is 0. Under continuous flow it moves one word per cycle.
- R6: MODE 2, when empty with valid_in at 1, drives valid_out to 1 and data_out to data_in in that same cycle. Under continuous flow it moves one word per cycle.
- R7: In MODE 3, valid_out rises only in the cycle after an accepted word. Under continuous flow it moves one word per cycle.
- R8: With ready_in held at 0 from empty, MODE 0, 1 and 2 accept exactly one word and MODE 3 accepts exactly two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Upstream word offered |
| data_in | input | WIDTH | Upstream word |
| ready_out | output | 1 | Stage can take a word this cycle |
| valid_out | output | 1 | Stage offers a word downstream |
| data_out | output | WIDTH | Downstream word |
| ready_in | input | 1 | Downstream takes the offered word |

## Verification
The bench drives all four modes side by side from the same ready_in, and each mode has its own sequence-numbered source. Continuous flow separates the half-rate cell from the three full-rate ones by its transfer count over a fixed window. A stall held from empty separates one-slot capacity from two-slot capacity. Same-cycle probes separate the combinational paths: ready_in to ready_out exists only in MODE 1, and valid_in to valid_out exists only in MODE 2. Pseudo-random stalls on both sides then exercise ordering, loss, duplication and the hold rule in every mode.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam int MODE_HALF  = 0;
  localparam int MODE_OVER  = 1;
  localparam int MODE_PASS  = 2;
  localparam int MODE_TWIN  = 3;

  function automatic int slot_count(input int mode);
    return (mode == MODE_TWIN) ? 2 : 1;
  endfunction
endpackage

// File: rtl/eb_slot.sv
module eb_slot #(
  parameter int W    = 16,
  parameter int KIND = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_up,
  input  logic [W-1:0] data_up,
  output logic         ready_up,
  output logic         valid_dn,
  output logic [W-1:0] data_dn,
  input  logic         ready_dn
);
  import eb_pkg::*;

  logic         full_q;
  logic         full_d;
  logic [W-1:0] word_q;
  logic         push;
  logic         pop;

  generate
    if (KIND == MODE_OVER) begin : g_over
      // accept while full when the held word leaves this cycle
      assign ready_up = ~full_q | ready_dn;
      assign valid_dn = full_q;
      assign data_dn  = word_q;
    end else if (KIND == MODE_PASS) begin : g_pass
      // empty slot forwards the incoming word directly
      assign ready_up = ~full_q;
      assign valid_dn = full_q | valid_up;
      assign data_dn  = full_q ? word_q : data_up;
    end else begin : g_half
      assign ready_up = ~full_q;
      assign valid_dn = full_q;
      assign data_dn  = word_q;
    end
  endgenerate

  assign push = valid_up & ready_up;
  assign pop  = valid_dn & ready_dn;

  always_comb begin
    if (KIND == MODE_PASS) begin
      // clear wins: a pass-through leaves the slot empty
      if (pop)       full_d = 1'b0;
      else if (push) full_d = 1'b1;
      else           full_d = full_q;
    end else begin
      if (push)      full_d = 1'b1;
      else if (pop)  full_d = 1'b0;
      else           full_d = full_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) full_q <= 1'b0;
    else     full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (push) word_q <= data_up;
  end
endmodule

// File: rtl/eb_twin.sv
module eb_twin #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic [W-1:0] data_in,
  output logic         ready_out,
  output logic         valid_out,
  output logic [W-1:0] data_out,
  input  logic         ready_in
);
  import eb_pkg::*;

  localparam int NSLOT = 2;

  logic             wr_ptr_q;
  logic             rd_ptr_q;
  logic [NSLOT-1:0] s_rdy;
  logic [NSLOT-1:0] s_vld;
  logic [W-1:0]     s_dat [NSLOT];
  logic             push;
  logic             pop;

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_cell
      eb_slot #(.W(W), .KIND(MODE_HALF)) u_cell (
        .clk      (clk),
        .rst      (rst),
        .valid_up (valid_in & (wr_ptr_q == 1'(i))),
        .data_up  (data_in),
        .ready_up (s_rdy[i]),
        .valid_dn (s_vld[i]),
        .data_dn  (s_dat[i]),
        .ready_dn (ready_in & (rd_ptr_q == 1'(i)))
      );
    end
  endgenerate

  assign ready_out = s_rdy[wr_ptr_q];
  assign valid_out = s_vld[rd_ptr_q];
  assign data_out  = s_dat[rd_ptr_q];
  assign push      = valid_in & ready_out;
  assign pop       = valid_out & ready_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= 1'b0;
      rd_ptr_q <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= ~wr_ptr_q;
      if (pop)  rd_ptr_q <= ~rd_ptr_q;
    end
  end
endmodule

// File: rtl/rv_elastic_stage.sv
module rv_elastic_stage #(
  parameter int WIDTH = 16,
  parameter int MODE  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [WIDTH-1:0] data_in,
  output logic             ready_out,
  output logic             valid_out,
  output logic [WIDTH-1:0] data_out,
  input  logic             ready_in
);
  import eb_pkg::*;

  generate
    if (MODE == MODE_TWIN) begin : g_twin
      eb_twin #(.W(WIDTH)) u_core (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .data_in   (data_in),
        .ready_out (ready_out),
        .valid_out (valid_out),
        .data_out  (data_out),
        .ready_in  (ready_in)
      );
    end else begin : g_single
      eb_slot #(.W(WIDTH), .KIND(MODE)) u_core (
        .clk      (clk),
        .rst      (rst),
        .valid_up (valid_in),
        .data_up  (data_in),
        .ready_up (ready_out),
        .valid_dn (valid_out),
        .data_dn  (data_out),
        .ready_dn (ready_in)
      );
    end
  endgenerate
endmodule

// File: rtl/eb_stage_chk.sv
module eb_stage_chk #(
  parameter int W    = 16,
  parameter int MODE = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_in,
  input logic [W-1:0] data_in,
  input logic         ready_out,
  input logic         valid_out,
  input logic [W-1:0] data_out,
  input logic         ready_in
);
  import eb_pkg::*;

  localparam int CAP = slot_count(MODE);

  logic       in_fire;
  logic       out_fire;
  logic [1:0] occ_q;

  assign in_fire  = valid_in & ready_out;
  assign out_fire = valid_out & ready_in;

  always_ff @(posedge clk) begin
    if (rst) occ_q <= 2'd0;
    else     occ_q <= occ_q + {1'b0, in_fire} - {1'b0, out_fire};
  end

  a_r3_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (valid_out && !ready_in) |=> valid_out);

  a_r3_hold_data: assert property (@(posedge clk) disable iff (rst)
    (valid_out && !ready_in) |=> $stable(data_out));

  a_r8_capacity: assert property (@(posedge clk) disable iff (rst)
    int'(occ_q) <= CAP);

  a_r2_valid_tracks: assert property (@(posedge clk) disable iff (rst)
    (MODE != MODE_PASS) |-> (valid_out == (occ_q != 2'd0)));

  a_r4_no_dual: assert property (@(posedge clk) disable iff (rst)
    (MODE == MODE_HALF) |-> !(in_fire && out_fire));

  a_r5_over_ready: assert property (@(posedge clk) disable iff (rst)
    (MODE == MODE_OVER && valid_out && ready_in) |-> ready_out);

  a_r7_reg_valid: assert property (@(posedge clk) disable iff (rst)
    (MODE != MODE_PASS && $rose(valid_out)) |-> $past(in_fire));

  a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
    (MODE == MODE_PASS && occ_q == 2'd0 && valid_in) |->
      (valid_out && data_out == data_in));
endmodule

bind rv_elastic_stage eb_stage_chk #(.W(WIDTH), .MODE(MODE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_in  (valid_in),
  .data_in   (data_in),
  .ready_out (ready_out),
  .valid_out (valid_out),
  .data_out  (data_out),
  .ready_in  (ready_in)
);

// File: tb/rv_elastic_stage_tb.sv
module rv_elastic_stage_tb;
  localparam int W      = 16;
  localparam int T_CLK  = 10;
  localparam int NM     = 4;
  localparam int WD_CYC = 20000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NM-1:0]   vin = '0;
  logic [NM-1:0]   rout;
  logic [NM-1:0]   vout;
  logic            rin = 1'b0;
  logic [W-1:0]    din  [NM];
  logic [W-1:0]    dout [NM];

  int  sent [NM];
  int  got  [NM];
  bit  in_f [NM];
  bit  out_f[NM];
  bit  hold_prev [NM];
  logic [W-1:0] dprev [NM];
  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #(T_CLK/2) clk = ~clk;

  generate
    for (genvar m = 0; m < NM; m++) begin : g_mode
      rv_elastic_stage #(.WIDTH(W), .MODE(m)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (vin[m]),
        .data_in   (din[m]),
        .ready_out (rout[m]),
        .valid_out (vout[m]),
        .data_out  (dout[m]),
        .ready_in  (rin)
      );
    end
  endgenerate

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_state();
    for (int m = 0; m < NM; m++) begin
      sent[m] = 0; got[m] = 0; in_f[m] = 0; out_f[m] = 0;
      hold_prev[m] = 0; dprev[m] = '0; din[m] = '0;
    end
  endtask

  // one clock: account previous transfers, drive, settle, check, advance
  task automatic cycle(input logic [NM-1:0] want_v, input bit r);
    for (int m = 0; m < NM; m++) begin
      if (in_f[m])  sent[m]++;
      if (out_f[m]) got[m]++;
      if (!(vin[m] && !in_f[m])) vin[m] = want_v[m];
      din[m] = W'(sent[m]);
    end
    rin = r;
    #1;
    for (int m = 0; m < NM; m++) begin
      if (hold_prev[m])
        check(vout[m] && dout[m] == dprev[m], $sformatf("R3 hold mode%0d", m),
              int'(dout[m]), int'(dprev[m]));
      in_f[m]  = vin[m] & rout[m];
      out_f[m] = vout[m] & rin;
      if (out_f[m])
        check(dout[m] == W'(got[m]), $sformatf("R2 order mode%0d", m),
              int'(dout[m]), got[m] & ((1 << W) - 1));
      if (m == 0)
        check(!(in_f[m] && out_f[m]), "R4 no dual transfer", 1, 0);
      hold_prev[m] = vout[m] & ~rin;
      dprev[m]     = dout[m];
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    vin = '0;
    rin = 1'b0;
    clear_state();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic drain();
    repeat (8) cycle('0, 1'b1);
    for (int m = 0; m < NM; m++)
      check(got[m] == sent[m], $sformatf("R2 no loss mode%0d", m), got[m], sent[m]);
  endtask

  task automatic t_reset();
    do_reset();
    for (int m = 0; m < NM; m++) begin
      check(vout[m] == 1'b0, $sformatf("R1 valid_out mode%0d", m), int'(vout[m]), 0);
      check(rout[m] == 1'b1, $sformatf("R1 ready_out mode%0d", m), int'(rout[m]), 1);
    end
  endtask

  task automatic t_stream();
    int g0 [NM];
    do_reset();
    repeat (10) cycle('1, 1'b1);
    for (int m = 0; m < NM; m++) g0[m] = got[m];
    repeat (20) cycle('1, 1'b1);
    check(got[0] - g0[0] == 10, "R4 half rate", got[0] - g0[0], 10);
    check(got[1] - g0[1] == 20, "R5 full rate", got[1] - g0[1], 20);
    check(got[2] - g0[2] == 20, "R6 full rate", got[2] - g0[2], 20);
    check(got[3] - g0[3] == 20, "R7 full rate", got[3] - g0[3], 20);
    drain();
  endtask

  task automatic t_stall();
    do_reset();
    repeat (5) cycle('1, 1'b0);
    for (int m = 0; m < NM; m++) begin
      check(sent[m] == ((m == 3) ? 2 : 1), $sformatf("R8 capacity mode%0d", m),
            sent[m], (m == 3) ? 2 : 1);
      check(vout[m] == 1'b1, $sformatf("R3 valid held mode%0d", m), int'(vout[m]), 1);
    end
    check(rout[0] == 1'b0, "R4 full blocks input", int'(rout[0]), 0);
    drain();
  endtask

  task automatic t_pass();
    do_reset();
    @(negedge clk);
    vin = '1;
    rin = 1'b1;
    for (int m = 0; m < NM; m++) din[m] = '0;
    #1;
    check(vout[2] == 1'b1 && dout[2] == din[2], "R6 same-cycle pass", int'(vout[2]), 1);
    check(vout[0] == 1'b0, "R4 no forward path", int'(vout[0]), 0);
    check(vout[1] == 1'b0, "R5 no forward path", int'(vout[1]), 0);
    check(vout[3] == 1'b0, "R7 registered valid", int'(vout[3]), 0);
    repeat (3) cycle('1, 1'b1);
    drain();
  endtask

  task automatic t_overlap();
    do_reset();
    repeat (3) cycle('1, 1'b0);
    rin = 1'b1;
    #1;
    check(rout[1] == 1'b1, "R5 ready follows ready_in high", int'(rout[1]), 1);
    check(rout[0] == 1'b0, "R4 ready ignores ready_in", int'(rout[0]), 0);
    check(rout[3] == 1'b0, "R7 ready ignores ready_in", int'(rout[3]), 0);
    rin = 1'b0;
    #1;
    check(rout[1] == 1'b0, "R5 ready follows ready_in low", int'(rout[1]), 0);
    drain();
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    for (int i = 0; i < 500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[3:0] | lfsr[7:4], lfsr[9] | (lfsr[11] & lfsr[2]));
    end
    drain();
  endtask

  initial begin
    clear_state();
    @(negedge clk);
    t_reset();
    t_stream();
    t_stall();
    t_pass();
    t_overlap();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule